// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

A small word-addressed memory in which every word carries a one-bit presence tag, either empty or full. Hardware threads use the tag to hand values from producer to consumer, and as a cheap lock. Synchronized accesses wait on the tag. A read that needs a full word, or a write that needs an empty word, is refused with a retry response when the tag is wrong. Refused accesses change nothing. Accesses that are accepted update the tag as part of the same access.

There is one request port. Each request carries an operation code, a word address, write data and a thread ID. The response appears combinationally in the same cycle: either done or retry, the read data and the echoed thread ID. State changes take effect at the next rising clock edge. The memory never queues a refused request, so the requesting thread issues it again later. Because the tag check and the tag update fall in the same cycle, and only one request is accepted per cycle, two lockers can never both take the same word.

Each word's tag is a two-state machine with states EMPTY and FULL. The transitions are:
- FILL (EMPTY or FULL to FULL) on an accepted synchronized store or unlock store.
- DRAIN (FULL or EMPTY to EMPTY) on an accepted locking load or mark-empty.
- KEEP for every other case.

The per-request decision has three outcomes: IDLE when there is no request, DONE and RETRY.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is FULL and every data word is zero.
- R2: A synchronized load (op 2) of a FULL word returns done with the word's data and leaves the tag FULL. On an EMPTY word it returns retry with read data zero.
- R3: A locking load (op 3) of a FULL word returns done with the data and makes the tag EMPTY. On an EMPTY word it returns retry.
- R4: A synchronized store (op 4) to an EMPTY word writes the data, makes the tag FULL and returns done. On a FULL word it returns retry.
- R5: Mark-empty (op 5) returns done, makes the tag EMPTY and leaves the data unchanged.
- R6: An unlock store (op 6) writes the data and makes the tag FULL whatever the prior tag, and returns done.
- R7: A retry is given in the same cycle as the request and leaves both data and tag unchanged.
- R8: A plain load (op 0) and a plain store (op 1) always return done, ignore the tag and never change it. A plain load returns the word's data.
- R9: Two locking loads of the same FULL word in consecutive cycles: the first returns done and the second returns retry.
- R10: With a request present, exactly one of done and retry is high and the thread ID is echoed. With no request, both are low and the read data is zero. Op 7 returns done and changes nothing. Read data is zero for every response that is not a done load (ops 0, 2, 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_tid | input | TID_W | Requesting thread ID |
| rsp_done | output | 1 | Request accepted |
| rsp_retry | output | 1 | Request refused, retry later |
| rsp_rdata | output | DATA_W | Read data for done loads, else zero |
| rsp_tid | output | TID_W | Echoed thread ID, zero when idle |

## Verification
Directed sequences first cover the producer/consumer handover on a single word:
- lock, then refused lock;
- refused synchronized load, then a synchronized store that fills the word;
- a refused second store, then mark-empty followed by an unlock store.

These separate a tag that moves correctly from one that is stuck, or one that a refused access still touches. Plain loads and stores aimed at EMPTY words show whether the tag is wrongly consulted or modified. A long random mix over all eight codes on a small address range makes tags flip often. It compares every response against a bench model of the tags and data, so a wrong transition for any code, full or empty, surfaces as a data or response mismatch later on.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        OP_LOAD         = 3'd0,
        OP_STORE        = 3'd1,
        OP_SYNC_LOAD    = 3'd2,
        OP_LOCK_LOAD    = 3'd3,
        OP_SYNC_STORE   = 3'd4,
        OP_MARK_EMPTY   = 3'd5,
        OP_UNLOCK_STORE = 3'd6,
        OP_NOP          = 3'd7
    } op_e;

    typedef enum logic {
        TAG_EMPTY = 1'b0,
        TAG_FULL  = 1'b1
    } tag_e;

    typedef enum logic [1:0] {
        TCMD_KEEP  = 2'd0,
        TCMD_FILL  = 2'd1,
        TCMD_DRAIN = 2'd2
    } tag_cmd_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_RETRY = 2'd2
    } rsp_e;

endpackage

// File: rtl/fe_decide.sv
module fe_decide
    import fe_pkg::*;
(
    input  logic     valid,
    input  op_e      op,
    input  tag_e     tag,
    output rsp_e     rsp,
    output logic     data_we,
    output tag_cmd_e tag_cmd,
    output logic     show_data
);

    always_comb begin
        rsp       = RSP_IDLE;
        data_we   = 1'b0;
        tag_cmd   = TCMD_KEEP;
        show_data = 1'b0;
        if (valid) begin
            rsp = RSP_DONE;
            unique case (op)
                OP_LOAD: begin
                    show_data = 1'b1;
                end
                OP_STORE: begin
                    data_we = 1'b1;
                end
                OP_SYNC_LOAD: begin
                    if (tag == TAG_FULL) begin
                        show_data = 1'b1;
                    end else begin
                        rsp = RSP_RETRY;
                    end
                end
                OP_LOCK_LOAD: begin
                    if (tag == TAG_FULL) begin
                        show_data = 1'b1;
                        tag_cmd   = TCMD_DRAIN;
                    end else begin
                        rsp = RSP_RETRY;
                    end
                end
                OP_SYNC_STORE: begin
                    if (tag == TAG_EMPTY) begin
                        data_we = 1'b1;
                        tag_cmd = TCMD_FILL;
                    end else begin
                        rsp = RSP_RETRY;
                    end
                end
                OP_MARK_EMPTY: begin
                    tag_cmd = TCMD_DRAIN;
                end
                OP_UNLOCK_STORE: begin
                    data_we = 1'b1;
                    tag_cmd = TCMD_FILL;
                end
                OP_NOP: begin
                    rsp = RSP_DONE;
                end
                default: begin
                    rsp = RSP_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fe_word.sv
module fe_word
    import fe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              data_we,
    input  tag_cmd_e          tag_cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data,
    output tag_e              tag
);

    tag_e tag_q;
    tag_e tag_d;

    // State register of the tag machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= TAG_FULL;
        end else begin
            tag_q <= tag_d;
        end
    end

    // Next-state: FILL, DRAIN or KEEP
    always_comb begin
        tag_d = tag_q;
        if (sel) begin
            unique case (tag_cmd)
                TCMD_FILL:  tag_d = TAG_FULL;
                TCMD_DRAIN: tag_d = TAG_EMPTY;
                TCMD_KEEP:  tag_d = tag_q;
                default:    tag_d = tag_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (sel && data_we) begin
            data <= wdata;
        end
    end

    assign tag = tag_q;

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
    import fe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TID_W-1:0]  req_tid,
    output logic              rsp_done,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [TID_W-1:0]  rsp_tid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_data [DEPTH];
    tag_e              word_tag  [DEPTH];
    logic [DEPTH-1:0]  tag_vec;

    op_e      op;
    rsp_e     rsp;
    logic     data_we;
    tag_cmd_e tag_cmd;
    logic     show_data;

    assign op = op_e'(req_op);

    fe_decide u_decide (
        .valid     (req_valid),
        .op        (op),
        .tag       (word_tag[req_addr]),
        .rsp       (rsp),
        .data_we   (data_we),
        .tag_cmd   (tag_cmd),
        .show_data (show_data)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        fe_word #(.DATA_W(DATA_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (req_valid && (req_addr == ADDR_W'(i))),
            .data_we (data_we),
            .tag_cmd (tag_cmd),
            .wdata   (req_wdata),
            .data    (word_data[i]),
            .tag     (word_tag[i])
        );
        assign tag_vec[i] = (word_tag[i] == TAG_FULL);
    end

    // Output process
    always_comb begin
        rsp_done  = 1'b0;
        rsp_retry = 1'b0;
        rsp_rdata = '0;
        rsp_tid   = '0;
        unique case (rsp)
            RSP_DONE: begin
                rsp_done = 1'b1;
                rsp_tid  = req_tid;
                if (show_data) begin
                    rsp_rdata = word_data[req_addr];
                end
            end
            RSP_RETRY: begin
                rsp_retry = 1'b1;
                rsp_tid   = req_tid;
            end
            RSP_IDLE: begin
                rsp_done = 1'b0;
            end
            default: begin
                rsp_done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TID_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [2:0]               req_op,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     rsp_done,
    input logic                     rsp_retry,
    input logic [DATA_W-1:0]        rsp_rdata,
    input logic [TID_W-1:0]         rsp_tid,
    input logic [(1<<ADDR_W)-1:0]   tag_vec
);

    AST_RESET_ALL_FULL: assert property (@(posedge clk) (rst_n && !$past(rst_n)) |-> (&tag_vec)); // R1

    AST_EMPTY_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd2 || req_op == 3'd3) && !tag_vec[req_addr]) |-> (rsp_retry && rsp_rdata == '0)); // R2

    AST_LOCK_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && rsp_done) |=> !tag_vec[$past(req_addr)]); // R3

    AST_FULL_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4 && tag_vec[req_addr]) |-> rsp_retry); // R4

    AST_SYNC_STORE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4 && rsp_done) |=> tag_vec[$past(req_addr)]); // R4

    AST_MARK_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |=> !tag_vec[$past(req_addr)]); // R5

    AST_UNLOCK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd6) |=> tag_vec[$past(req_addr)]); // R6

    AST_RETRY_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_retry) |=> $stable(tag_vec)); // R7

    AST_PLAIN_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd0 || req_op == 3'd1)) |=> $stable(tag_vec)); // R8

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot({rsp_done, rsp_retry})); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_done && !rsp_retry && rsp_rdata == '0 && rsp_tid == '0)); // R10

endmodule

bind fe_sync_mem fe_sync_mem_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TID_W (TID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .rsp_done  (rsp_done),
    .rsp_retry (rsp_retry),
    .rsp_rdata (rsp_rdata),
    .rsp_tid   (rsp_tid),
    .tag_vec   (tag_vec)
);

// File: tb/fe_sync_mem_test.sv
module fe_sync_mem_test;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int TID_W  = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [TID_W-1:0]  req_tid = '0;
    logic              rsp_done;
    logic              rsp_retry;
    logic [DATA_W-1:0] rsp_rdata;
    logic [TID_W-1:0]  rsp_tid;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] m_data [DEPTH];
    bit                m_full [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    fe_sync_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tid(req_tid),
        .rsp_done(rsp_done), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .rsp_tid(rsp_tid)
    );

    // Acceptance per the requirements: 2,3 need FULL; 4 needs EMPTY; others always
    function automatic bit accepts(input logic [2:0] op, input bit full);
        case (op)
            3'd2, 3'd3: return full;
            3'd4:       return !full;
            default:    return 1'b1;
        endcase
    endfunction

    function automatic bit returns_data(input logic [2:0] op);
        return (op == 3'd0 || op == 3'd2 || op == 3'd3);
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R8";
            3'd2:       return "R2";
            3'd3:       return "R3";
            3'd4:       return "R4";
            3'd5:       return "R5";
            3'd6:       return "R6";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int addr, input logic [DATA_W-1:0] wd,
                         input logic [TID_W-1:0] tid, input string rq);
        bit ok;
        logic [DATA_W-1:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        req_tid   = tid;
        #(CLK_P/4);
        ok     = accepts(op, m_full[addr]);
        exp_rd = (ok && returns_data(op)) ? m_data[addr] : '0;
        check(rq, "done/retry/tid/rdata",
              {30'd0, rsp_done, rsp_retry, 12'd0, rsp_tid, rsp_rdata},
              {30'd0, ok, !ok, 12'd0, tid, exp_rd});
        if (ok) begin
            case (op)
                3'd1:    m_data[addr] = wd;
                3'd3:    m_full[addr] = 1'b0;
                3'd4:    begin m_data[addr] = wd; m_full[addr] = 1'b1; end
                3'd5:    m_full[addr] = 1'b0;
                3'd6:    begin m_data[addr] = wd; m_full[addr] = 1'b1; end
                default: ;
            endcase
        end
    endtask

    task automatic go_idle(input string rq);
        @(negedge clk);
        req_valid = 1'b0;
        req_tid   = 4'hF;
        #(CLK_P/4);
        check(rq, "idle outputs", {rsp_done, rsp_retry, rsp_tid, rsp_rdata}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < DEPTH; i++) begin
            m_data[i] = '0;
            m_full[i] = 1'b1;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        go_idle("R10");
        // R1: all words zero and FULL after reset
        for (int i = 0; i < DEPTH; i++) issue(3'd0, i, '0, 4'd1, "R1");
        issue(3'd2, 9, '0, 4'd2, "R1");

        // R3 / R9: lock then immediate second lock on same word
        issue(3'd6, 3, 16'hBEEF, 4'd1, "R6");
        issue(3'd3, 3, '0, 4'd2, "R9");
        issue(3'd3, 3, '0, 4'd3, "R9");
        // R2 / R7: consumer refused on EMPTY, data hidden
        issue(3'd2, 3, '0, 4'd4, "R2");
        // R8: plain load ignores EMPTY tag
        issue(3'd0, 3, '0, 4'd5, "R8");
        // R4: producer fills, then second producer refused
        issue(3'd4, 3, 16'h1234, 4'd6, "R4");
        issue(3'd4, 3, 16'h5678, 4'd7, "R7");
        issue(3'd2, 3, '0, 4'd8, "R2");
        issue(3'd2, 3, '0, 4'd8, "R2");
        // R5: mark empty keeps data, early consumer blocked
        issue(3'd5, 5, 16'hFFFF, 4'd9, "R5");
        issue(3'd2, 5, '0, 4'd9, "R5");
        issue(3'd0, 5, '0, 4'd9, "R5");
        // R8: plain store to EMPTY word keeps it EMPTY
        issue(3'd1, 5, 16'hAAAA, 4'd10, "R8");
        issue(3'd2, 5, '0, 4'd10, "R8");
        // R6: unlock store on EMPTY and on FULL word
        issue(3'd6, 5, 16'h0F0F, 4'd11, "R6");
        issue(3'd2, 5, '0, 4'd11, "R6");
        issue(3'd6, 5, 16'h7777, 4'd11, "R6");
        issue(3'd3, 5, '0, 4'd11, "R6");
        // R10: op 7 does nothing
        issue(3'd7, 5, 16'h9999, 4'd12, "R10");
        issue(3'd0, 5, '0, 4'd12, "R10");
        issue(3'd4, 5, 16'h4242, 4'd12, "R10");
        go_idle("R10");

        // Random mix on a narrow address range so tags flip often
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            issue(op, int'($urandom_range(0, 5)), 16'($urandom), 4'($urandom), req_of(op));
            if (($urandom & 32'hF) == 0) go_idle("R10");
        end
        go_idle("R10");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule